// File: doc/BRIEF.md
# Third-Order Cascaded Divide-Ratio Modulator

This block sets the divide ratio of a multi-modulus feedback divider in a fractional-N synthesizer. It runs on the divided feedback clock. On every enabled edge it produces a small signed correction, and it adds that correction to the integer divide value. The long-run average of the divide ratio is then the integer part plus a fraction `frac_i / 2^W`. The correction comes from three first-order accumulator stages in cascade. Stage one adds the fractional word. Stages two and three each add the residue that the stage before them has just produced, not the residue it held before the edge.

A recombination network passes the carry of each stage through a difference filter. The filter order rises with the stage: the stage-one carry goes through unchanged, the stage-two carry gets one difference and the stage-three carry gets two. The sum of the three filtered carries is a multi-level offset. Because the quantization error of each stage is cancelled by the next stage, the error that remains is pushed to high frequency. The offset is registered and stays constant between enabled edges. The divide value is formed at full width, so it never wraps.

Top module: `mash_divmod`

## Requirements
- R1: After reset, and before the first enabled edge, `offset_o` is 0 and `div_o` equals `nint_i`.
- R2: `offset_o` is a 4-bit two's-complement value and always lies between -3 and +4 inclusive. An enabled edge that follows an offset of +4 produces an offset of 0 or less.
- R3: When `en_i` is low at a rising edge, no state changes: `offset_o` holds its value, and the sequence continues where it stopped once `en_i` returns high.
- R4: While every fractional word applied on an enabled edge since reset has been 0, `offset_o` stays 0.
- R5: Let S be the sum of the offsets produced over the enabled edges since reset, and let F be the sum of the fractional words applied on those same edges. Then S·2^W − F lies in the interval (−2^(W+1), 2^(W+1)]. As a result, the average divide value converges to N + frac/2^W.
- R6: With W = 8, a constant fractional word of 1 from reset gives an offset of 0 after each of the first 10 enabled edges. The offset is +1 after the 11th edge, when the third stage first carries, and −2 after the 12th edge.
- R7: `div_o` is the signed (NW+2)-bit value `nint_i + offset_o`, and it never wraps. With `nint_i` = 0 it can be negative, and with `nint_i` = 2^NW − 1 it can exceed 2^NW − 1.
- R8: A step in the fractional word partway through a run, upward by 2 or by 4 or back down, introduces no overflow error. The bound of R5, taken with the new words included in F, keeps holding after the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided feedback clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Update enable; state advances only on edges where it is high |
| frac_i | input | W | Fractional word K, read as K/2^W |
| nint_i | input | NW | Integer divide value N |
| offset_o | output | 4 | Signed divide-ratio offset, −3..+4 |
| div_o | output | NW+2 | Signed instantaneous divide value N + offset |

## Verification
The hardest outcomes to reach from the ports are the extreme offsets and the first third-stage carry. Both depend on the hidden residues of all three stages lining up. The stimulus reaches them in two ways. Long runs use fractional words spread across the range, including 2^W − 1, and the bench accumulates the offsets against the R5 bound on every edge, so that a wrong carry or a wrong difference term is caught wherever it occurs. A run with K = 1 from reset has a timeline that can be worked out by hand: the third-stage carry first appears on the eleventh edge. That run pins exact values and also exercises the hold behaviour in the middle of the sequence.

// File: rtl/mash_pkg.sv
package mash_pkg;
    localparam int STAGES = 3;
    localparam int OFS_W  = 4;
    typedef logic signed [OFS_W-1:0] ofs_t;
endpackage

// File: rtl/mash_acc.sv
module mash_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] add_i,
    output logic [W-1:0] res_o,
    output logic         carry_o
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, add_i};
        res_o   = sum[W-1:0];
        carry_o = sum[W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (en_i) begin
            acc_q <= sum[W-1:0];
        end
    end
endmodule

// File: rtl/mash_recomb.sv
module mash_recomb
    import mash_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [STAGES-1:0] carry_i,
    output ofs_t              offset_o
);
    logic c2_d1, c3_d1, c3_d2;
    ofs_t next_ofs;

    // c1 + (c2 - c2z) + (c3 - 2*c3z + c3zz), in 4-bit modular arithmetic
    always_comb begin
        next_ofs = ofs_t'({3'b000, carry_i[0]})
                 + ofs_t'({3'b000, carry_i[1]})
                 - ofs_t'({3'b000, c2_d1})
                 + ofs_t'({3'b000, carry_i[2]})
                 - ofs_t'({2'b00, c3_d1, 1'b0})
                 + ofs_t'({3'b000, c3_d2});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c2_d1    <= 1'b0;
            c3_d1    <= 1'b0;
            c3_d2    <= 1'b0;
            offset_o <= '0;
        end else if (en_i) begin
            c2_d1    <= carry_i[1];
            c3_d1    <= carry_i[2];
            c3_d2    <= c3_d1;
            offset_o <= next_ofs;
        end
    end
endmodule

// File: rtl/mash_divmod.sv
module mash_divmod
    import mash_pkg::*;
#(
    parameter int W  = 8,
    parameter int NW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic [W-1:0]         frac_i,
    input  logic [NW-1:0]        nint_i,
    output logic signed [3:0]    offset_o,
    output logic signed [NW+1:0] div_o
);
    localparam int DW = NW + 2;

    logic [W-1:0]      stage_in  [STAGES];
    logic [W-1:0]      stage_res [STAGES];
    logic [STAGES-1:0] carries;
    ofs_t              ofs_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign stage_in[i] = frac_i;
        end else begin : g_tail
            assign stage_in[i] = stage_res[i-1];
        end
        mash_acc #(.W(W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (en_i),
            .add_i   (stage_in[i]),
            .res_o   (stage_res[i]),
            .carry_o (carries[i])
        );
    end

    mash_recomb u_recomb (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .carry_i  (carries),
        .offset_o (ofs_q)
    );

    assign offset_o = ofs_q;
    assign div_o    = $signed({2'b00, nint_i}) + $signed({{(DW-OFS_W){ofs_q[OFS_W-1]}}, ofs_q});
endmodule

// File: rtl/mash_divmod_chk.sv
module mash_divmod_chk #(
    parameter int W  = 8,
    parameter int NW = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en_i,
    input logic [W-1:0]         frac_i,
    input logic [NW-1:0]        nint_i,
    input logic signed [3:0]    offset_o,
    input logic signed [NW+1:0] div_o
);
    logic zero_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero_run <= 1'b1;
        end else if (en_i && frac_i != '0) begin
            zero_run <= 1'b0;
        end
    end

    // R2
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (offset_o >= -4'sd3) && (offset_o <= 4'sd4));

    // R2
    peak_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && offset_o == 4'sd4) |=> (offset_o <= 4'sd0));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(offset_o));

    // R4
    zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_run |-> (offset_o == 4'sd0));
endmodule

bind mash_divmod mash_divmod_chk #(.W(W), .NW(NW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .frac_i   (frac_i),
    .nint_i   (nint_i),
    .offset_o (offset_o),
    .div_o    (div_o)
);

// File: tb/sim_mash_divmod.sv
module sim_mash_divmod;
    localparam int W  = 8;
    localparam int NW = 8;
    localparam int M  = 1 << W;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 en_i = 1'b0;
    logic [W-1:0]         frac_i = '0;
    logic [NW-1:0]        nint_i = '0;
    logic signed [3:0]    offset_o;
    logic signed [NW+1:0] div_o;

    int checks = 0;
    int fails  = 0;
    longint sum_ofs = 0;
    longint sum_k   = 0;

    // {K, N, edges}
    localparam logic [31:0] VEC [6] = '{
        {8'd1,   8'd73,  16'd300},
        {8'd128, 8'd100, 16'd300},
        {8'd255, 8'd255, 16'd600},
        {8'd37,  8'd0,   16'd520},
        {8'd200, 8'd2,   16'd400},
        {8'd85,  8'd150, 16'd300}
    };

    mash_divmod #(.W(W), .NW(NW)) u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .frac_i(frac_i),
        .nint_i(nint_i), .offset_o(offset_o), .div_o(div_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        en_i = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        sum_ofs = 0;
        sum_k = 0;
        @(negedge clk);
    endtask

    // one edge; sample at the following falling edge
    task automatic step(input bit en, input logic [W-1:0] k);
        longint err;
        en_i = en;
        frac_i = k;
        @(negedge clk);
        if (en) begin
            sum_ofs += offset_o;
            sum_k   += k;
            err = sum_ofs * M - sum_k;
            // R2
            chk(offset_o >= -3 && offset_o <= 4, "R2", offset_o, 0);
            // R5 / R8
            chk(err > -2 * M && err <= 2 * M, "R5", err, 0);
            // R7
            chk(div_o == longint'(nint_i) + offset_o, "R7", div_o, longint'(nint_i) + offset_o);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic signed [3:0] held;
        nint_i = 8'd73;
        do_reset();
        // R1
        chk(offset_o == 0, "R1", offset_o, 0);
        chk(div_o == 73, "R1", div_o, 73);

        for (int v = 0; v < 6; v++) begin
            do_reset();
            nint_i = VEC[v][23:16];
            for (int e = 0; e < int'(VEC[v][15:0]); e++) step(1'b1, VEC[v][31:24]);
        end

        // R4
        do_reset();
        for (int e = 0; e < 300; e++) begin
            step(1'b1, '0);
            chk(offset_o == 0, "R4", offset_o, 0);
        end

        // R6, R7 (N = 0 gives a negative divide value), R3
        do_reset();
        nint_i = '0;
        for (int e = 0; e < 10; e++) begin
            step(1'b1, 8'd1);
            chk(offset_o == 0, "R6", offset_o, 0);
        end
        step(1'b1, 8'd1);
        chk(offset_o == 1, "R6", offset_o, 1);
        held = offset_o;
        for (int e = 0; e < 5; e++) begin
            step(1'b0, 8'd200);
            chk(offset_o == held, "R3", offset_o, held);
        end
        step(1'b1, 8'd1);
        chk(offset_o == -2, "R6", offset_o, -2);
        chk(div_o == -2, "R7", div_o, -2);

        // R7 top of range
        do_reset();
        nint_i = 8'd255;
        for (int e = 0; e < 11; e++) step(1'b1, 8'd1);
        chk(div_o == 256, "R7", div_o, 256);

        // R8 steps of +2, +4 and back down
        do_reset();
        nint_i = 8'd73;
        for (int e = 0; e < 300; e++) step(1'b1, 8'd40);
        for (int e = 0; e < 300; e++) step(1'b1, 8'd42);
        for (int e = 0; e < 300; e++) step(1'b1, 8'd46);
        for (int e = 0; e < 300; e++) step(1'b1, 8'd252);
        for (int e = 0; e < 300; e++) step(1'b1, 8'd3);
        chk(1'b1, "R8", 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule